// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns the levels on a small set of dedicated interrupt pins into interrupt requests. Each pin has a two-bit sense field in a shared 8-bit control register. The field selects one of four behaviours: the request follows a low level on the pin, or the block latches a flag on any change, on a falling edge or on a rising edge. A request leaves the block only when the global interrupt enable and that channel's mask bit are both set.

In level mode the path from pin to request has no clocked element, so it keeps working while the I/O clock is stopped. Edge modes sample the pin on clock edges qualified by an I/O clock enable and keep the result in a sticky flag. Software clears the flag by writing a one to it, or the interrupt controller clears it with an acknowledge. Writing a new sense value resynchronises the channel's sample history to the pin, so the change of mode cannot report an edge that did not happen. The block has no pin-direction input, so a pin that the chip drives as an output still raises requests, which gives software a way to trigger an interrupt.

Top module: `extirq_sense`

## Requirements
- R1: After reset the control register reads 0x00, all flags are 0, and no request is raised while the pins are high.
- R2: The sense field of channel c sits at control bits [2c+1:2c] (channel 0 at [1:0], channel 1 at [3:2]). Bits above the fields ignore writes and read as zero.
- R3: Sense value 00 selects low level. The request equals the inverted pin level with no clock edge in between, and it stays asserted while the pin is low, even with the I/O clock enable at 0.
- R4: Sense value 01 sets the channel flag on both a rising and a falling change of the pin.
- R5: Sense value 10 sets the flag on a falling edge only.
- R6: Sense value 11 sets the flag on a rising edge only.
- R7: With one sample stage, a pin change applied between clock edges shows on the flag after the second following rising clock edge. A pulse that covers at least one full clock period is always captured.
- R8: While the I/O clock enable is 0, the edge-mode sample history is frozen. A pulse that starts and ends during that time sets no flag.
- R9: A flag is cleared by a one on its clear input or its acknowledge input. A new edge in the same cycle wins, and the flag stays set.
- R10: The request of a channel is asserted only when the global enable and the channel mask bit are both 1.
- R11: A write that changes a sense field reloads that channel's sample history with the current pin level, so no edge is flagged for a pin change that happened before the write.
- R12: In level mode a cleared flag stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_clk_en | input | 1 | I/O clock running; qualifies edge sampling |
| pin_i | input | NUM_CH | Interrupt pin levels |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | REG_W | Control register write data |
| ctl_rdata_o | output | REG_W | Control register read data |
| flag_clr_i | input | NUM_CH | Write-one-to-clear of the flags |
| ack_i | input | NUM_CH | Interrupt acknowledge per channel |
| mask_i | input | NUM_CH | Per-channel interrupt mask (1 = enabled) |
| gie_i | input | 1 | Global interrupt enable |
| flag_o | output | NUM_CH | Sticky edge flags |
| irq_o | output | NUM_CH | Gated interrupt requests |

## Verification
The bench builds the block with its defaults: two channels, an 8-bit register, one sample stage and pins that idle high at reset. With one sample stage the flag latency is exactly two clock edges, so a single-period pulse and an exact-cycle timing check can be tested. Two channels put both register fields within reach, so the field placement and the reserved upper nibble can be checked. The vector table covers every sense encoding on both channels, and the directed cases cover stopped-clock pulses, resynchronisation on a mode change, and a clear that lands in the same cycle as a new edge.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
   localparam int unsigned SENSE_W = 2;

   typedef enum logic [SENSE_W-1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;
endpackage

// File: rtl/extirq_ctl_reg.sv
module extirq_ctl_reg
   import extirq_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned REG_W  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_i,
   input  logic [REG_W-1:0]                wdata_i,
   output logic [REG_W-1:0]                rdata_o,
   output logic [NUM_CH-1:0][SENSE_W-1:0]  sense_o,
   output logic [NUM_CH-1:0]               reload_o
);
   localparam int unsigned USED_W = NUM_CH * SENSE_W;

   logic [NUM_CH-1:0][SENSE_W-1:0] field_q;
   logic [NUM_CH-1:0][SENSE_W-1:0] wr_field;

   assign wr_field = wdata_i[USED_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    field_q <= '0;
      else if (wr_i) field_q <= wr_field;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chg
      assign reload_o[c] = wr_i && (wr_field[c] != field_q[c]);
   end

   if (REG_W > USED_W) begin : g_rsvd
      logic rsvd_unused;
      assign rsvd_unused = ^wdata_i[REG_W-1:USED_W];
      assign rdata_o = {{(REG_W-USED_W){1'b0}}, field_q};
   end else begin : g_full
      assign rdata_o = field_q;
   end

   assign sense_o = field_q;

   // R2: a write lands in the field bits on the next edge
   p_field_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (sense_o == $past(wdata_i[USED_W-1:0])));
endmodule

// File: rtl/extirq_edge_det.sv
module extirq_edge_det
   import extirq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 1,
   parameter bit          PIN_RESET   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_clk_en,
   input  logic               pin_i,
   input  logic               reload_i,
   input  logic [SENSE_W-1:0] mode_i,
   output logic               hit_o
);
   logic [SYNC_STAGES-1:0] samp_q;
   logic                   prev_q;
   logic                   cur;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         samp_q <= PIN_RESET;
         else if (reload_i)  samp_q <= pin_i;
         else if (io_clk_en) samp_q <= pin_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         samp_q <= {SYNC_STAGES{PIN_RESET}};
         else if (reload_i)  samp_q <= {SYNC_STAGES{pin_i}};
         else if (io_clk_en) samp_q <= {samp_q[SYNC_STAGES-2:0], pin_i};
      end
   end

   assign cur = samp_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prev_q <= PIN_RESET;
      else if (reload_i)  prev_q <= pin_i;
      else if (io_clk_en) prev_q <= cur;
   end

   logic rise, fall;
   assign rise = io_clk_en && !reload_i && !prev_q &&  cur;
   assign fall = io_clk_en && !reload_i &&  prev_q && !cur;

   always_comb begin
      unique case (sense_e'(mode_i))
         SENSE_ANY:  hit_o = rise || fall;
         SENSE_FALL: hit_o = fall;
         SENSE_RISE: hit_o = rise;
         default:    hit_o = 1'b0;
      endcase
   end

   // R8: history frozen while the I/O clock is stopped
   p_hold_noclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_clk_en && !reload_i) |=> $stable(prev_q));
   // R11: mode change reloads history from the pin
   p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (prev_q == $past(pin_i)));
endmodule

// File: rtl/extirq_flag.sv
module extirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   // R4: a detected edge is latched
   p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R9: clear without a competing edge empties the flag
   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/extirq_sense.sv
module extirq_sense
   import extirq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYNC_STAGES = 1,
   parameter bit          PIN_RESET   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_clk_en,
   input  logic [NUM_CH-1:0] pin_i,
   input  logic              ctl_wr_i,
   input  logic [REG_W-1:0]  ctl_wdata_i,
   output logic [REG_W-1:0]  ctl_rdata_o,
   input  logic [NUM_CH-1:0] flag_clr_i,
   input  logic [NUM_CH-1:0] ack_i,
   input  logic [NUM_CH-1:0] mask_i,
   input  logic              gie_i,
   output logic [NUM_CH-1:0] flag_o,
   output logic [NUM_CH-1:0] irq_o
);
   localparam int unsigned USED_W = NUM_CH * SENSE_W;

   if (NUM_CH < 1 || USED_W > REG_W) begin : g_bad_width
      $error("extirq_sense: %0d channels do not fit a %0d-bit register", NUM_CH, REG_W);
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("extirq_sense: SYNC_STAGES must be 1..3");
   end

   logic [NUM_CH-1:0][SENSE_W-1:0] sense;
   logic [NUM_CH-1:0]              reload;
   logic [NUM_CH-1:0]              hit;

   extirq_ctl_reg #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (ctl_wr_i),
      .wdata_i  (ctl_wdata_i),
      .rdata_o  (ctl_rdata_o),
      .sense_o  (sense),
      .reload_o (reload)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic level_mode;
      assign level_mode = (sense_e'(sense[c]) == SENSE_LOW);

      extirq_edge_det #(.SYNC_STAGES(SYNC_STAGES), .PIN_RESET(PIN_RESET)) u_det (
         .clk       (clk),
         .rst_n     (rst_n),
         .io_clk_en (io_clk_en),
         .pin_i     (pin_i[c]),
         .reload_i  (reload[c]),
         .mode_i    (sense[c]),
         .hit_o     (hit[c])
      );

      extirq_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (hit[c]),
         .clr_i  (flag_clr_i[c] || ack_i[c]),
         .flag_o (flag_o[c])
      );

      // level path is purely combinational so it survives a stopped clock
      assign irq_o[c] = gie_i && mask_i[c] && (level_mode ? !pin_i[c] : flag_o[c]);

      // R12: level mode never latches a flag
      p_level_no_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (level_mode && !flag_o[c]) |=> !flag_o[c]);
      // R10: disabled global enable keeps the request low at every edge
      p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (!gie_i || !mask_i[c]) |-> !irq_o[c]);
   end
endmodule

// File: tb/extirq_sense_test.sv
module extirq_sense_test;
   localparam int NCH = 2;
   localparam int RW  = 8;

   typedef struct packed {
      logic       ch;
      logic [1:0] mode;
      logic       p0;
      logic       p1;
      logic       exp;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
      '{1'b0, 2'b01, 1'b1, 1'b0, 1'b1},
      '{1'b0, 2'b01, 1'b0, 1'b1, 1'b1},
      '{1'b0, 2'b10, 1'b1, 1'b0, 1'b1},
      '{1'b0, 2'b10, 1'b0, 1'b1, 1'b0},
      '{1'b0, 2'b11, 1'b0, 1'b1, 1'b1},
      '{1'b0, 2'b11, 1'b1, 1'b0, 1'b0},
      '{1'b1, 2'b00, 1'b1, 1'b0, 1'b0},
      '{1'b1, 2'b01, 1'b0, 1'b1, 1'b1},
      '{1'b1, 2'b10, 1'b1, 1'b0, 1'b1},
      '{1'b1, 2'b11, 1'b0, 1'b1, 1'b1},
      '{1'b1, 2'b11, 1'b1, 1'b0, 1'b0}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           io_clk_en = 1'b1;
   logic [NCH-1:0] pin = '1;
   logic           ctl_wr = 1'b0;
   logic [RW-1:0]  ctl_wdata = '0;
   logic [RW-1:0]  ctl_rdata;
   logic [NCH-1:0] flag_clr = '0;
   logic [NCH-1:0] ack = '0;
   logic [NCH-1:0] mask = '1;
   logic           gie = 1'b1;
   logic [NCH-1:0] flag;
   logic [NCH-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   extirq_sense uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .io_clk_en   (io_clk_en),
      .pin_i       (pin),
      .ctl_wr_i    (ctl_wr),
      .ctl_wdata_i (ctl_wdata),
      .ctl_rdata_o (ctl_rdata),
      .flag_clr_i  (flag_clr),
      .ack_i       (ack),
      .mask_i      (mask),
      .gie_i       (gie),
      .flag_o      (flag),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [RW-1:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic clr_all();
      flag_clr = '1;
      @(negedge clk);
      flag_clr = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctl", ctl_rdata, 8'h00);
      chk("R1 flag", flag, 2'b00);
      chk("R1 irq", irq, 2'b00);

      // R2 reserved bits and field placement
      wr_ctl(8'hF6);
      chk("R2 rsvd", ctl_rdata, 8'h06);

      // vector table: each sense value on each channel
      foreach (VECS[k]) begin
         vec_t v = VECS[k];
         int   c = int'(v.ch);
         logic [RW-1:0] w;
         pin[c] = v.p0;
         cycles(3);
         w = (c == 0) ? {4'h0, 2'b11, v.mode} : {4'h0, v.mode, 2'b11};
         wr_ctl(w);
         clr_all();
         pin[c] = v.p1;
         cycles(3);
         chk($sformatf("R3-6 vec%0d flag (R4 R5 R6 R12)", k), flag[c], v.exp);
         chk($sformatf("R3 vec%0d irq", k), irq[c], (v.mode == 2'b00) ? !v.p1 : v.exp);
         pin = '1;
         cycles(3);
      end

      // R7 latency and single-period pulse
      pin[0] = 1'b0;
      cycles(3);
      wr_ctl(8'h0F);
      clr_all();
      pin[0] = 1'b1;
      @(negedge clk);
      chk("R7 one edge", flag[0], 1'b0);
      @(negedge clk);
      chk("R7 two edges", flag[0], 1'b1);
      pin[0] = 1'b0;
      cycles(3);
      clr_all();
      pin[0] = 1'b1;
      @(negedge clk);
      pin[0] = 1'b0;
      cycles(3);
      chk("R7 short pulse", flag[0], 1'b1);
      pin = '1;
      cycles(2);

      // R8 pulse during stopped clock
      wr_ctl(8'h05);
      clr_all();
      io_clk_en = 1'b0;
      pin[0] = 1'b0;
      cycles(2);
      pin[0] = 1'b1;
      cycles(2);
      io_clk_en = 1'b1;
      cycles(3);
      chk("R8 no flag", flag[0], 1'b0);

      // R11 mode change resyncs history
      io_clk_en = 1'b0;
      pin[0] = 1'b0;
      cycles(2);
      wr_ctl(8'h06);
      io_clk_en = 1'b1;
      cycles(3);
      chk("R11 no false edge", flag[0], 1'b0);
      pin[0] = 1'b1;
      cycles(3);

      // R9 acknowledge, write-one-clear, and set-wins
      wr_ctl(8'h05);
      clr_all();
      pin[0] = 1'b0;
      cycles(3);
      chk("R9 set", flag[0], 1'b1);
      ack[0] = 1'b1;
      @(negedge clk);
      ack[0] = 1'b0;
      chk("R9 ack clears", flag[0], 1'b0);
      pin[0] = 1'b1;
      cycles(3);
      flag_clr[0] = 1'b1;
      @(negedge clk);
      flag_clr[0] = 1'b0;
      chk("R9 w1c clears", flag[0], 1'b0);
      pin[0] = 1'b0;
      @(negedge clk);
      flag_clr[0] = 1'b1;
      @(negedge clk);
      flag_clr[0] = 1'b0;
      chk("R9 set wins", flag[0], 1'b1);
      pin[0] = 1'b1;
      cycles(3);

      // R10 and R3: gating and clock-free level path
      wr_ctl(8'h00);
      pin[0] = 1'b0;
      #1;
      chk("R3 level", irq[0], 1'b1);
      gie = 1'b0;
      #1;
      chk("R10 gie off", irq[0], 1'b0);
      gie = 1'b1; mask = 2'b10;
      #1;
      chk("R10 mask off", irq[0], 1'b0);
      mask = 2'b11; io_clk_en = 1'b0;
      cycles(2);
      chk("R3 no clock", irq[0], 1'b1);
      pin[0] = 1'b1;
      #1;
      chk("R3 release", irq[0], 1'b0);
      io_clk_en = 1'b1;
      clr_all();
      pin[0] = 1'b0;
      cycles(3);
      chk("R12 level no flag", flag[0], 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule